// File: doc/BRIEF.md
# Hardware Breakpoint Match Unit

This block watches every instruction fetch and data access that the core issues. It compares each one against a small set of programmable linear-address breakpoints. Each breakpoint slot has its own address register and its own access-type qualifier and length field. Each slot also has a local enable and a global enable. When an enabled slot matches, the block records the hit in a sticky status register and raises a one-cycle debug-exception pulse. The core also reports single-step traps and task switches to the block. Both are recorded as trap causes. A task switch also wipes the task-local enables.

Software reaches the address, status and control registers through a simple register port. The port accepts an access only in real mode or at privilege level 0. A guard bit in the control register turns any such access into a debug trap instead of a transfer. Exception delivery, retirement and privilege tracking stay outside the block; the current mode and privilege come in as inputs.

Top module: `brk_watch`

## Requirements
- R1: After synchronous reset, every address, status and control register reads as zero, and `dbg_exc`, `reg_reject` and `reg_rdata` are low.
- R2: Register select 0..NBP-1 addresses the breakpoint addresses, NBP the status word and NBP+1 the control word. Any other select reads zero and ignores writes. A write takes effect on the next edge, and read data appears on `reg_rdata` in the cycle after `reg_en`. Every `reg_en` cycle that is not a permitted read loads zero into `reg_rdata`. Control layout for NBP=4:
  - bits 3:0 are the local enables;
  - bits 7:4 are the global enables;
  - bit 8 is local exact;
  - bit 9 is global exact;
  - bit 10 is the guard;
  - bits 12:11+2i hold the type of slot i;
  - bits 20:19+2i hold the length of slot i;
  - the upper bits read zero.
- R3: A register access is permitted only when `cpu_real` is 1 or `cpu_priv` is 0. A refused access changes nothing and reads zero, and `reg_reject` pulses in the next cycle.
- R4: Type 00 (execute) matches only a fetch (`acc_kind` 00) whose address equals the slot address exactly. The slot's length field is ignored.
- R5: Type 01 matches data writes (`acc_kind` 01) only. Type 11 matches data reads (`acc_kind` 10) or writes. Type 10 never matches.
- R6: Data lengths and access sizes are both encoded as 00 = 1 byte, 01 = 2, 11 or 10 = 4. The slot address is aligned down to its length. A data match needs any byte of the access to overlap that range, and an access running past the top address still counts its low bytes.
- R7: A slot takes part only when its local or global enable is set, and nothing matches while `acc_valid` is low.
- R8: Status bits 3:0 are the per-slot hit flags. Bit NBP is the guard trip, bit NBP+1 is single step and bit NBP+2 is task switch. Each is set one cycle after its cause and is never cleared by hardware. A software write replaces the word, but a cause in the same cycle still sets its bit.
- R9: `dbg_exc` is high in the cycle after any cause and low after a cycle with none. The causes are an enabled match, a guard trip, a single-step trap and a task switch.
- R10: With the guard bit set, a permitted access does not transfer and reads zero. It sets the guard-trip status bit, pulses `dbg_exc` and clears the guard bit.
- R11: A `step_trap` cycle sets the single-step status bit and pulses `dbg_exc`.
- R12: A `task_switch` cycle clears every local enable and the local-exact bit. It keeps the global enables and the global-exact bit, sets the task-switch status bit and pulses `dbg_exc`. It overrides a control write made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_kind | input | 2 | 00 fetch, 01 write, 10 read |
| acc_addr | input | AW | Linear address of the access |
| acc_size | input | 2 | Access size code |
| step_trap | input | 1 | Single-step trap cause |
| task_switch | input | 1 | Task switch cause |
| cpu_real | input | 1 | Core is in real mode |
| cpu_priv | input | 2 | Current privilege level |
| reg_en | input | 1 | Register port access |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_sel | input | SELW | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| reg_reject | output | 1 | Access refused for privilege |
| dbg_exc | output | 1 | Debug-exception pulse |

## Verification
The bench builds the block with its default four slots and a 32-bit address. With those values all four type encodings sit side by side in one control word, so cross-slot interference shows up. A four-byte access at the very top of the address space checks the carry-extended overlap arithmetic. The reference model runs every cycle. It covers guard disarming, same-cycle status writes against new hits, and task switches that coincide with control writes.

// File: rtl/brk_pkg.sv
package brk_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_READ  = 2'b10,
    ACC_NONE  = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    BP_EXEC  = 2'b00,
    BP_WRITE = 2'b01,
    BP_OFF   = 2'b10,
    BP_RDWR  = 2'b11
  } bp_type_e;

  // Byte count for a length or size code.
  function automatic logic [2:0] span_bytes(input logic [1:0] code);
    case (code)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/brk_slot.sv
module brk_slot
  import brk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] bp_addr,
  input  logic          bp_en,
  input  logic [1:0]    bp_type,
  input  logic [1:0]    bp_len,
  input  logic          acc_valid,
  input  logic [1:0]    acc_kind,
  input  logic [AW-1:0] acc_addr,
  input  logic [1:0]    acc_size,
  output logic          hit
);

  // One extra bit so that an access at the top of the space does not wrap.
  localparam int EW = AW + 1;

  logic [EW-1:0] b_span, a_span;
  logic [EW-1:0] b_lo, b_hi, a_lo, a_hi;
  logic          kind_ok, exec_slot, overlap, exact;

  always_comb begin
    b_span = EW'(span_bytes(bp_len));
    a_span = EW'(span_bytes(acc_size));
    b_lo   = {1'b0, bp_addr} & ~(b_span - EW'(1));
    b_hi   = b_lo + b_span - EW'(1);
    a_lo   = {1'b0, acc_addr};
    a_hi   = a_lo + a_span - EW'(1);
  end

  assign overlap = (a_lo <= b_hi) && (b_lo <= a_hi);
  assign exact   = (acc_addr == bp_addr);

  always_comb begin
    exec_slot = 1'b0;
    kind_ok   = 1'b0;
    case (bp_type)
      BP_EXEC: begin
        exec_slot = 1'b1;
        kind_ok   = (acc_kind == ACC_FETCH);
      end
      BP_WRITE: kind_ok = (acc_kind == ACC_WRITE);
      BP_RDWR:  kind_ok = (acc_kind == ACC_WRITE) || (acc_kind == ACC_READ);
      default:  kind_ok = 1'b0;
    endcase
  end

  assign hit = acc_valid & bp_en & kind_ok & (exec_slot ? exact : overlap);

endmodule

// File: rtl/brk_status.sv
module brk_status #(
  parameter int NBP = 4,
  localparam int SW = NBP + 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NBP-1:0] hit_vec,
  input  logic           guard_trip,
  input  logic           step_trap,
  input  logic           task_switch,
  input  logic           sw_wr,
  input  logic [SW-1:0]  sw_data,
  output logic [SW-1:0]  status_q,
  output logic           dbg_exc
);

  logic [SW-1:0] set_vec;
  logic [SW-1:0] base;

  assign set_vec = {task_switch, step_trap, guard_trip, hit_vec};
  assign base    = sw_wr ? sw_data : status_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      dbg_exc  <= 1'b0;
    end else begin
      status_q <= base | set_vec;
      dbg_exc  <= |set_vec;
    end
  end

endmodule

// File: rtl/brk_watch.sv
module brk_watch
  import brk_pkg::*;
#(
  parameter int NBP = 4,
  parameter int AW  = 32,
  localparam int SELW = $clog2(NBP + 2)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            acc_valid,
  input  logic [1:0]      acc_kind,
  input  logic [AW-1:0]   acc_addr,
  input  logic [1:0]      acc_size,
  input  logic            step_trap,
  input  logic            task_switch,
  input  logic            cpu_real,
  input  logic [1:0]      cpu_priv,
  input  logic            reg_en,
  input  logic            reg_wr,
  input  logic [SELW-1:0] reg_sel,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            reg_reject,
  output logic            dbg_exc
);

  localparam int CW     = 6 * NBP + 3;
  localparam int SW     = NBP + 3;
  localparam int LE_BIT = 2 * NBP;
  localparam int GE_BIT = 2 * NBP + 1;
  localparam int GD_BIT = 2 * NBP + 2;
  localparam int TY_LSB = 2 * NBP + 3;
  localparam int LN_LSB = 4 * NBP + 3;
  localparam logic [SELW-1:0] SEL_STAT = SELW'(NBP);
  localparam logic [SELW-1:0] SEL_CTRL = SELW'(NBP + 1);

  logic [AW-1:0]  bp_addr_q [NBP];
  logic [CW-1:0]  ctrl_q, ctrl_d;
  logic [SW-1:0]  status_q;
  logic [NBP-1:0] hit_vec;
  logic [NBP-1:0] addr_wr;
  logic           acc_ok, guarded, guard_trip, port_go;
  logic           stat_sw_wr, ctrl_wr;
  logic [31:0]    rd_mux;
  logic           unused_wdata;

  assign unused_wdata = ^reg_wdata[31:CW];

  // Port permission and guard.
  assign acc_ok     = cpu_real | (cpu_priv == 2'd0);
  assign guarded    = ctrl_q[GD_BIT];
  assign guard_trip = reg_en & acc_ok & guarded;
  assign port_go    = reg_en & acc_ok & ~guarded;
  assign stat_sw_wr = port_go & reg_wr & (reg_sel == SEL_STAT);
  assign ctrl_wr    = port_go & reg_wr & (reg_sel == SEL_CTRL);

  // Breakpoint slots.
  for (genvar g = 0; g < NBP; g++) begin : g_slot
    assign addr_wr[g] = port_go & reg_wr & (reg_sel == SELW'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        bp_addr_q[g] <= '0;
      end else if (addr_wr[g]) begin
        bp_addr_q[g] <= reg_wdata[AW-1:0];
      end
    end

    brk_slot #(.AW(AW)) u_slot (
      .bp_addr   (bp_addr_q[g]),
      .bp_en     (ctrl_q[g] | ctrl_q[NBP + g]),
      .bp_type   (ctrl_q[TY_LSB + 2*g +: 2]),
      .bp_len    (ctrl_q[LN_LSB + 2*g +: 2]),
      .acc_valid (acc_valid),
      .acc_kind  (acc_kind),
      .acc_addr  (acc_addr),
      .acc_size  (acc_size),
      .hit       (hit_vec[g])
    );
  end

  // Control register: software write, then guard disarm, then task wipe.
  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) begin
      ctrl_d = reg_wdata[CW-1:0];
    end
    if (guard_trip) begin
      ctrl_d[GD_BIT] = 1'b0;
    end
    if (task_switch) begin
      ctrl_d[NBP-1:0] = '0;
      ctrl_d[LE_BIT]  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
    end
  end

  // Status and exception pulse.
  brk_status #(.NBP(NBP)) u_status (
    .clk         (clk),
    .rst         (rst),
    .hit_vec     (hit_vec),
    .guard_trip  (guard_trip),
    .step_trap   (step_trap),
    .task_switch (task_switch),
    .sw_wr       (stat_sw_wr),
    .sw_data     (reg_wdata[SW-1:0]),
    .status_q    (status_q),
    .dbg_exc     (dbg_exc)
  );

  // Read path.
  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NBP; i++) begin
      if (reg_sel == SELW'(i)) begin
        rd_mux = 32'(bp_addr_q[i]);
      end
    end
    if (reg_sel == SEL_STAT) begin
      rd_mux = 32'(status_q);
    end
    if (reg_sel == SEL_CTRL) begin
      rd_mux = 32'(ctrl_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata  <= '0;
      reg_reject <= 1'b0;
    end else begin
      reg_reject <= reg_en & ~acc_ok;
      if (reg_en) begin
        reg_rdata <= (port_go && !reg_wr) ? rd_mux : 32'd0;
      end
    end
  end

endmodule

// File: rtl/brk_watch_chk.sv
module brk_watch_chk #(
  parameter int NBP = 4,
  parameter int AW  = 32,
  localparam int CW = 6 * NBP + 3,
  localparam int SW = NBP + 3
) (
  input logic           clk,
  input logic           rst,
  input logic           reg_en,
  input logic           cpu_real,
  input logic [1:0]     cpu_priv,
  input logic           step_trap,
  input logic           task_switch,
  input logic           reg_reject,
  input logic           dbg_exc,
  input logic [NBP-1:0] hit_vec,
  input logic           guard_trip,
  input logic           stat_sw_wr,
  input logic           ctrl_wr,
  input logic [SW-1:0]  status_q,
  input logic [CW-1:0]  ctrl_q
);

  localparam int LE_BIT = 2 * NBP;
  localparam int GE_BIT = 2 * NBP + 1;

  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    !stat_sw_wr |=> ((status_q & $past(status_q)) == $past(status_q)));

  a_r12_local_clear: assert property (@(posedge clk) disable iff (rst)
    task_switch |=> (ctrl_q[NBP-1:0] == '0) && !ctrl_q[LE_BIT]);

  a_r12_global_kept: assert property (@(posedge clk) disable iff (rst)
    (task_switch && !ctrl_wr) |=>
      (ctrl_q[2*NBP-1:NBP] == $past(ctrl_q[2*NBP-1:NBP])) &&
      (ctrl_q[GE_BIT] == $past(ctrl_q[GE_BIT])));

  a_r11_step: assert property (@(posedge clk) disable iff (rst)
    step_trap |=> status_q[NBP+1] && dbg_exc);

  a_r10_guard: assert property (@(posedge clk) disable iff (rst)
    guard_trip |=> status_q[NBP] && dbg_exc && !reg_reject);

  a_r3_reject: assert property (@(posedge clk) disable iff (rst)
    (reg_en && !cpu_real && cpu_priv != 2'd0) |=> reg_reject);

  a_r9_quiet: assert property (@(posedge clk) disable iff (rst)
    (hit_vec == '0 && !guard_trip && !step_trap && !task_switch) |=> !dbg_exc);

  a_r8_hit_flag: assert property (@(posedge clk) disable iff (rst)
    (hit_vec != '0) |=> ((status_q[NBP-1:0] & $past(hit_vec)) == $past(hit_vec)));

endmodule

bind brk_watch brk_watch_chk #(.NBP(NBP), .AW(AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .reg_en      (reg_en),
  .cpu_real    (cpu_real),
  .cpu_priv    (cpu_priv),
  .step_trap   (step_trap),
  .task_switch (task_switch),
  .reg_reject  (reg_reject),
  .dbg_exc     (dbg_exc),
  .hit_vec     (hit_vec),
  .guard_trip  (guard_trip),
  .stat_sw_wr  (stat_sw_wr),
  .ctrl_wr     (ctrl_wr),
  .status_q    (status_q),
  .ctrl_q      (ctrl_q)
);

// File: tb/test_brk_watch.sv
module test_brk_watch;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic [1:0]  acc_kind = 2'b00;
  logic [31:0] acc_addr = '0;
  logic [1:0]  acc_size = 2'b00;
  logic        step_trap = 1'b0;
  logic        task_switch = 1'b0;
  logic        cpu_real = 1'b0;
  logic [1:0]  cpu_priv = 2'd0;
  logic        reg_en = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_reject;
  logic        dbg_exc;

  int n_chk = 0;
  int n_bad = 0;
  bit run = 1'b0;
  bit ended = 1'b0;

  brk_watch i_brk_watch (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_kind(acc_kind),
    .acc_addr(acc_addr), .acc_size(acc_size), .step_trap(step_trap),
    .task_switch(task_switch), .cpu_real(cpu_real), .cpu_priv(cpu_priv),
    .reg_en(reg_en), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_reject(reg_reject), .dbg_exc(dbg_exc)
  );

  always #(CLK_P/2) clk = ~clk;

  // Reference model state.
  logic [31:0] m_addr [4];
  logic [31:0] m_ctrl, m_rd;
  logic [6:0]  m_stat;
  logic        m_exc, m_rej;

  function automatic int nbytes(input logic [1:0] c);
    return (c == 2'b00) ? 1 : (c == 2'b01) ? 2 : 4;
  endfunction

  function automatic bit model_hit(input logic en, input logic [1:0] t,
      input logic [1:0] l, input logic [31:0] bp, input logic v,
      input logic [1:0] k, input logic [31:0] a, input logic [1:0] s);
    longint blo, bhi, alo, ahi;
    if (!en || !v) return 1'b0;
    if (t == 2'b00) return (k == 2'b00) && (a == bp);
    if (t == 2'b10) return 1'b0;
    if (t == 2'b01 && k != 2'b01) return 1'b0;
    if (t == 2'b11 && k != 2'b01 && k != 2'b10) return 1'b0;
    blo = longint'(bp) - (longint'(bp) % nbytes(l));
    bhi = blo + nbytes(l) - 1;
    alo = longint'(a);
    ahi = alo + nbytes(s) - 1;
    return (alo <= bhi) && (blo <= ahi);
  endfunction

  always @(posedge clk) begin : mdl
    logic       legal, gd, go;
    logic [3:0] h;
    logic [31:0] nctrl, rmux;
    logic [6:0] nstat;
    if (rst) begin
      for (int i = 0; i < 4; i++) m_addr[i] = '0;
      m_ctrl = '0; m_rd = '0; m_stat = '0; m_exc = 1'b0; m_rej = 1'b0;
    end else begin
      legal = cpu_real || (cpu_priv == 2'd0);
      gd    = m_ctrl[10];
      go    = reg_en && legal && !gd;
      for (int i = 0; i < 4; i++)
        h[i] = model_hit(m_ctrl[i] | m_ctrl[4+i], m_ctrl[11+2*i +: 2],
                         m_ctrl[19+2*i +: 2], m_addr[i], acc_valid,
                         acc_kind, acc_addr, acc_size);
      rmux = 32'd0;
      if (reg_sel < 3'd4) rmux = m_addr[reg_sel[1:0]];
      else if (reg_sel == 3'd4) rmux = {25'd0, m_stat};
      else if (reg_sel == 3'd5) rmux = m_ctrl;
      nstat = m_stat;
      nctrl = m_ctrl;
      if (go && reg_wr) begin
        if (reg_sel < 3'd4) m_addr[reg_sel[1:0]] = reg_wdata;
        if (reg_sel == 3'd4) nstat = reg_wdata[6:0];
        if (reg_sel == 3'd5) nctrl = reg_wdata & 32'h07FF_FFFF;
      end
      if (reg_en && legal && gd) nctrl[10] = 1'b0;
      if (task_switch) begin
        nctrl[3:0] = 4'd0;
        nctrl[8] = 1'b0;
      end
      nstat = nstat | {task_switch, step_trap, (reg_en && legal && gd), h};
      m_exc = (|h) || (reg_en && legal && gd) || step_trap || task_switch;
      m_rej = reg_en && !legal;
      if (reg_en) m_rd = (go && !reg_wr) ? rmux : 32'd0;
      m_stat = nstat;
      m_ctrl = nctrl;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (run && !rst) begin
      chk(dbg_exc === m_exc, "R9 dbg_exc vs model", 32'(dbg_exc), 32'(m_exc));
      chk(reg_rdata === m_rd, "R2 reg_rdata vs model", reg_rdata, m_rd);
      chk(reg_reject === m_rej, "R3 reg_reject vs model", 32'(reg_reject), 32'(m_rej));
    end
  end

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic acc(input logic [1:0] k, input logic [31:0] a, input logic [1:0] s);
    acc_valid = 1'b1; acc_kind = k; acc_addr = a; acc_size = s;
    cyc();
    acc_valid = 1'b0;
  endtask

  task automatic wreg(input logic [2:0] sel, input logic [31:0] d);
    reg_en = 1'b1; reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    cyc();
    reg_en = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] sel, output logic [31:0] d);
    reg_en = 1'b1; reg_wr = 1'b0; reg_sel = sel;
    cyc();
    reg_en = 1'b0;
    d = reg_rdata;
  endtask

  task automatic exp_exc(input bit e, input string req);
    chk(dbg_exc === e, req, 32'(dbg_exc), 32'(e));
  endtask

  task automatic exp_reg(input logic [2:0] sel, input logic [31:0] e, input string req);
    logic [31:0] d;
    rreg(sel, d);
    chk(d === e, req, d, e);
  endtask

  function automatic logic [31:0] mk(input logic [3:0] l, input logic [3:0] g,
      input logic le, input logic ge, input logic gd,
      input logic [7:0] ty, input logic [7:0] ln);
    return {5'd0, ln, ty, gd, ge, le, g, l};
  endfunction

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  localparam logic [1:0] KF = 2'b00, KW = 2'b01, KR = 2'b10;
  localparam logic [7:0] TY_A = 8'b11_01_11_00;
  localparam logic [7:0] TY_B = 8'b11_10_11_00;
  localparam logic [7:0] LN_A = 8'b01_01_11_11;

  initial begin
    repeat (2) cyc();
    rst = 1'b0;
    run = 1'b1;
    // R1 reset state
    chk(dbg_exc === 1'b0 && reg_reject === 1'b0 && reg_rdata === 32'd0,
        "R1 outputs after reset", {reg_rdata[29:0], reg_reject, dbg_exc}, 32'd0);
    for (int i = 0; i < 6; i++) exp_reg(3'(i), 32'd0, "R1 register zero after reset");

    // R2 register port
    wreg(3'd0, 32'h0000_1000);
    wreg(3'd1, 32'h0000_2003);
    wreg(3'd2, 32'h0000_3000);
    wreg(3'd3, 32'hFFFF_FFFF);
    exp_reg(3'd0, 32'h0000_1000, "R2 slot0 readback");
    exp_reg(3'd1, 32'h0000_2003, "R2 slot1 readback");
    exp_reg(3'd3, 32'hFFFF_FFFF, "R2 slot3 readback");
    wreg(3'd6, 32'h5);
    exp_reg(3'd6, 32'd0, "R2 unmapped select reads zero");

    // R3 privilege
    cpu_priv = 2'd3;
    wreg(3'd0, 32'hDEAD);
    chk(reg_reject === 1'b1, "R3 reject pulse", 32'(reg_reject), 32'd1);
    cyc();
    chk(reg_reject === 1'b0, "R3 reject one cycle", 32'(reg_reject), 32'd0);
    cpu_real = 1'b1;
    exp_reg(3'd0, 32'h0000_1000, "R3 refused write ignored, real mode read ok");
    cpu_real = 1'b0; cpu_priv = 2'd0;

    wreg(3'd5, mk(4'b0101, 4'b1010, 1'b0, 1'b0, 1'b0, TY_A, LN_A));

    // R4 execute slot
    acc(KF, 32'h1000, 2'b00);
    exp_exc(1'b1, "R4 fetch hit");
    exp_reg(3'd4, 32'h1, "R4 status B0");
    wreg(3'd4, 32'd0);
    acc(KF, 32'h1001, 2'b00);
    exp_exc(1'b0, "R4 fetch off by one");
    acc(KR, 32'h1000, 2'b00);
    exp_exc(1'b0, "R4 read at exec address");

    // R6 overlap and alignment
    acc(KR, 32'h2001, 2'b00);
    exp_exc(1'b1, "R6 inside aligned range");
    acc(KR, 32'h1FFC, 2'b11);
    exp_exc(1'b0, "R6 adjacent below");
    acc(KR, 32'h1FFE, 2'b11);
    exp_exc(1'b1, "R6 partial overlap");
    acc(KW, 32'h2004, 2'b00);
    exp_exc(1'b0, "R6 adjacent above");
    acc(KF, 32'h2000, 2'b00);
    exp_exc(1'b0, "R5 rdwr ignores fetch");
    exp_reg(3'd4, 32'h2, "R6 status B1");
    wreg(3'd4, 32'd0);

    // R5 write-only slot
    acc(KW, 32'h3001, 2'b00);
    exp_exc(1'b1, "R5 write hit");
    acc(KR, 32'h3000, 2'b00);
    exp_exc(1'b0, "R5 read on write slot");
    acc(KW, 32'h3002, 2'b01);
    exp_exc(1'b0, "R6 two-byte boundary");
    exp_reg(3'd4, 32'h4, "R5 status B2");
    wreg(3'd4, 32'd0);

    // R6 top of space
    acc(KR, 32'hFFFF_FFFC, 2'b11);
    exp_exc(1'b1, "R6 top range hit");
    acc(KW, 32'hFFFF_FFFF, 2'b11);
    exp_exc(1'b1, "R6 access past top");

    // R5 never type
    wreg(3'd5, mk(4'b0101, 4'b1010, 1'b0, 1'b0, 1'b0, TY_B, LN_A));
    acc(KW, 32'h3000, 2'b00);
    exp_exc(1'b0, "R5 type 10 never matches");
    repeat (3) cyc();
    exp_reg(3'd4, 32'h8, "R8 sticky over idle");

    // R7 enables
    wreg(3'd5, mk(4'b0100, 4'b1010, 1'b0, 1'b0, 1'b0, TY_A, LN_A));
    acc(KF, 32'h1000, 2'b00);
    exp_exc(1'b0, "R7 disabled slot");
    acc_kind = KR; acc_addr = 32'h2000; acc_size = 2'b00; acc_valid = 1'b0;
    cyc();
    exp_exc(1'b0, "R7 no valid no match");

    // R8 write vs same-cycle hit
    reg_en = 1'b1; reg_wr = 1'b1; reg_sel = 3'd4; reg_wdata = 32'd0;
    acc_valid = 1'b1; acc_kind = KR; acc_addr = 32'h2000;
    cyc();
    reg_en = 1'b0; reg_wr = 1'b0; acc_valid = 1'b0;
    exp_reg(3'd4, 32'h2, "R8 hit wins over clearing write");
    wreg(3'd4, 32'h7F);
    exp_reg(3'd4, 32'h7F, "R8 write replaces");
    wreg(3'd4, 32'd0);

    // R11 single step, R9 pulse
    step_trap = 1'b1; cyc(); step_trap = 1'b0;
    exp_exc(1'b1, "R11 step pulse");
    cyc();
    exp_exc(1'b0, "R9 pulse ends");
    exp_reg(3'd4, 32'h20, "R11 status BS");
    step_trap = 1'b1; cyc(); cyc(); step_trap = 1'b0;
    exp_exc(1'b1, "R9 back-to-back causes");

    // R12 task switch
    wreg(3'd5, mk(4'b1111, 4'b0011, 1'b1, 1'b1, 1'b0, TY_A, LN_A));
    task_switch = 1'b1; cyc(); task_switch = 1'b0;
    exp_exc(1'b1, "R12 task switch pulse");
    exp_reg(3'd5, mk(4'b0000, 4'b0011, 1'b0, 1'b1, 1'b0, TY_A, LN_A), "R12 locals cleared");
    exp_reg(3'd4, 32'h60, "R12 status BT");
    reg_en = 1'b1; reg_wr = 1'b1; reg_sel = 3'd5;
    reg_wdata = mk(4'b1111, 4'b0001, 1'b1, 1'b0, 1'b0, TY_A, LN_A);
    task_switch = 1'b1;
    cyc();
    reg_en = 1'b0; reg_wr = 1'b0; task_switch = 1'b0;
    exp_reg(3'd5, mk(4'b0000, 4'b0001, 1'b0, 1'b0, 1'b0, TY_A, LN_A), "R12 overrides write");

    // R10 guard
    wreg(3'd4, 32'd0);
    wreg(3'd5, mk(4'b0000, 4'b0001, 1'b0, 1'b0, 1'b1, TY_A, LN_A));
    wreg(3'd0, 32'hBEEF);
    exp_exc(1'b1, "R10 guard trip pulse");
    chk(reg_reject === 1'b0, "R10 not a privilege reject", 32'(reg_reject), 32'd0);
    exp_reg(3'd4, 32'h10, "R10 status BD, guard disarmed");
    exp_reg(3'd0, 32'h1000, "R10 blocked write");
    wreg(3'd5, mk(4'b0000, 4'b0001, 1'b0, 1'b0, 1'b1, TY_A, LN_A));
    exp_reg(3'd0, 32'd0, "R10 guarded read returns zero");
    exp_exc(1'b1, "R10 guarded read trips");
    exp_reg(3'd5, mk(4'b0000, 4'b0001, 1'b0, 1'b0, 1'b0, TY_A, LN_A), "R10 guard bit cleared");

    repeat (2) cyc();
    finish_run();
  end

endmodule